// File: doc/BRIEF.md
# Level-Interrupt End-of-Service Handler with Storm Throttle

The block handles end-of-interrupt notices for a bank of redirection entries in an interrupt router. A notice carries a vector number, a flag saying whether it is level-type, and a suppression input. On each notice the block walks every redirection entry, one entry per clock. For every entry whose vector equals the notice it sends an acknowledge pulse to that pin. For a level-type notice without suppression, it also tells the table to drop the entry's remote-pending flag. If the pin is then unmasked and still pending, the block asks the delivery logic to send it again.

A misbehaving level source can re-assert at once after every end-of-interrupt. To detect this, a per-pin counter tracks back-to-back immediate redeliveries. When a pin's counter reaches a limit, that redelivery is withheld and one shared timer is started. When the timer expires, every level pin that is pending and not remote-pending is redelivered together. The entry table itself and message formatting stay outside the block.

The controller has two named states. `ST_IDLE` holds `eoi_ready` high. The transition *accept* (valid notice) moves it to `ST_SCAN`. `ST_SCAN` keeps `busy` high and visits entries 0 to NPINS-1 in order. The transition *finish*, taken after the last entry, returns it to `ST_IDLE`.

Top module: `eoi_throttle`

## Requirements
- R1: A notice is applied to every entry whose 8-bit vector equals the notice vector. Entries are visited in ascending index order, one per clock cycle, and matching entries k and j>k produce outputs exactly j-k cycles apart.
- R2: Each matching entry produces a one-cycle `ack_pulse` on its bit, whatever the notice type and suppression input.
- R3: `remote_clr` pulses for a matching entry only when `eoi_level`=1 and `eoi_suppress`=0. It pulses in the same cycle as that entry's acknowledge.
- R4: When remote-pending is cleared and the pin is unmasked (`ent_mask`=0) and pending (`pin_pending`=1), its storm counter increments and `redeliver` pulses for that pin in the same cycle. Otherwise the counter returns to zero.
- R5: When an increment would bring a pin's counter to STORM_LIMIT, the counter returns to zero and no immediate redelivery is issued for that pin. The sweep timer is armed instead.
- R6: The sweep fires SWEEP_DELAY cycles after the arming cycle. In that cycle `redeliver` is high for every pin with `ent_level`=1, `pin_pending`=1 and `ent_remote`=0.
- R7: Arming while the sweep timer is running does not restart it. Only one sweep fires, timed from the first arming.
- R8: Reset cancels a running sweep and clears all storm counters.
- R9: `eoi_ready` is low and `busy` high while a scan is in progress. A scan lasts NPINS cycles, and a held notice is accepted NPINS+1 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | Notice present |
| eoi_ready | output | 1 | Notice accepted when high with valid |
| eoi_vector | input | VEC_W | Vector carried by the notice |
| eoi_level | input | 1 | Notice is level-type |
| eoi_suppress | input | 1 | Directed end-of-interrupt suppression; blocks remote-pending clearing |
| ent_vector | input | NPINS*VEC_W | Vector field of each entry, entry i at bits i*VEC_W |
| ent_level | input | NPINS | Entry is level-triggered |
| ent_mask | input | NPINS | Entry is masked |
| ent_remote | input | NPINS | Entry remote-pending flag |
| pin_pending | input | NPINS | Pin pending (request register) |
| busy | output | 1 | Scan in progress |
| ack_pulse | output | NPINS | Acknowledge notification per matched pin |
| remote_clr | output | NPINS | Clear request for an entry's remote-pending flag |
| redeliver | output | NPINS | Redelivery request to the delivery logic |

## Verification
The bench builds the block with NPINS=24 and VEC_W=8, as in the default. It uses STORM_LIMIT=3 and SWEEP_DELAY=100, so a storm is reached after three notices and the sweep fires within a hundred cycles. With these values the bench can check the exact timer latency. It can also check the second arming, made one cycle later by a second pin on the same vector, and a reset that lands while the timer is still counting. These are all reached in a few thousand cycles, and the full scan width of 24 entries is still exercised.

// File: rtl/eoi_throttle_pkg.sv
package eoi_throttle_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;
endpackage

// File: rtl/eoi_scan_fsm.sv
module eoi_scan_fsm
    import eoi_throttle_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int VEC_W = 8,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     eoi_valid,
    input  logic [VEC_W-1:0]         eoi_vector,
    input  logic                     eoi_level,
    input  logic                     eoi_suppress,
    input  logic [NPINS*VEC_W-1:0]   ent_vector,
    output logic                     eoi_ready,
    output logic                     busy,
    output logic [IDX_W-1:0]         scan_idx,
    output logic                     hit,
    output logic                     clear_en
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPINS - 1);

    scan_state_t        state, state_nx;
    logic [VEC_W-1:0]   vec_q;
    logic               lvl_q;
    logic               sup_q;
    logic               accept;

    assign accept = eoi_valid && (state == ST_IDLE);

    // state register and notice latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            vec_q    <= '0;
            lvl_q    <= 1'b0;
            sup_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                vec_q <= eoi_vector;
                lvl_q <= eoi_level;
                sup_q <= eoi_suppress;
            end
            if (state == ST_SCAN && scan_idx != LAST_IDX)
                scan_idx <= scan_idx + 1'b1;
            else
                scan_idx <= '0;
        end
    end

    // transitions: accept, finish
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (eoi_valid)            state_nx = ST_SCAN;
            ST_SCAN: if (scan_idx == LAST_IDX) state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eoi_ready = 1'b0;
        busy      = 1'b0;
        hit       = 1'b0;
        clear_en  = 1'b0;
        unique case (state)
            ST_IDLE: eoi_ready = 1'b1;
            ST_SCAN: begin
                busy     = 1'b1;
                hit      = (ent_vector[int'(scan_idx)*VEC_W +: VEC_W] == vec_q);
                clear_en = hit && lvl_q && !sup_q;
            end
        endcase
    end

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_ready) |=> (busy && !eoi_ready));

    assert_scan_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && scan_idx != LAST_IDX) |=> (busy && scan_idx == $past(scan_idx) + 1'b1));

    assert_clear_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en |-> (hit && busy));
endmodule

// File: rtl/storm_counter_bank.sv
module storm_counter_bank #(
    parameter int NPINS       = 24,
    parameter int STORM_LIMIT = 10000,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1,
    localparam int CNT_W = $clog2(STORM_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [IDX_W-1:0] idx,
    input  logic             eligible,
    output logic             storm_hit,
    output logic             redo_now
);
    logic [CNT_W-1:0] cnt [NPINS];
    logic [CNT_W-1:0] cnt_sel;

    always_comb begin
        cnt_sel = '0;
        for (int i = 0; i < NPINS; i++)
            if (idx == IDX_W'(i)) cnt_sel = cnt[i];
    end

    assign storm_hit = upd && eligible && ((cnt_sel + 1'b1) == CNT_W'(STORM_LIMIT));
    assign redo_now  = upd && eligible && !storm_hit;

    for (genvar g = 0; g < NPINS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (upd && idx == IDX_W'(g)) begin
                if (!eligible || storm_hit)
                    cnt[g] <= '0;
                else
                    cnt[g] <= cnt[g] + 1'b1;
            end
        end

        assert_cnt_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] < CNT_W'(STORM_LIMIT));
    end

    assert_ineligible_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !eligible) |=> (cnt_sel == '0 || idx != $past(idx)));
endmodule

// File: rtl/sweep_timer.sv
module sweep_timer #(
    parameter int SWEEP_DELAY = 2500000,
    localparam int TW = $clog2(SWEEP_DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    logic [TW-1:0] remain;
    logic          running;

    assign running = (remain != '0);
    assign fire    = (remain == TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (running)
            remain <= remain - 1'b1;
        else if (arm)
            remain <= TW'(SWEEP_DELAY);
    end

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && arm) |=> (remain == $past(remain) - 1'b1));

    assert_arm_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && arm) |=> (remain == TW'(SWEEP_DELAY)));
endmodule

// File: rtl/eoi_throttle.sv
module eoi_throttle #(
    parameter int NPINS       = 24,
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000,
    parameter int SWEEP_DELAY = 2500000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eoi_valid,
    output logic                   eoi_ready,
    input  logic [VEC_W-1:0]       eoi_vector,
    input  logic                   eoi_level,
    input  logic                   eoi_suppress,
    input  logic [NPINS*VEC_W-1:0] ent_vector,
    input  logic [NPINS-1:0]       ent_level,
    input  logic [NPINS-1:0]       ent_mask,
    input  logic [NPINS-1:0]       ent_remote,
    input  logic [NPINS-1:0]       pin_pending,
    output logic                   busy,
    output logic [NPINS-1:0]       ack_pulse,
    output logic [NPINS-1:0]       remote_clr,
    output logic [NPINS-1:0]       redeliver
);
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [IDX_W-1:0] scan_idx;
    logic             hit, clear_en;
    logic             eligible, storm_hit, redo_now;
    logic             sweep_fire;
    logic [NPINS-1:0] scan_redo;
    logic [NPINS-1:0] sweep_set;

    eoi_scan_fsm #(.NPINS(NPINS), .VEC_W(VEC_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .eoi_valid    (eoi_valid),
        .eoi_vector   (eoi_vector),
        .eoi_level    (eoi_level),
        .eoi_suppress (eoi_suppress),
        .ent_vector   (ent_vector),
        .eoi_ready    (eoi_ready),
        .busy         (busy),
        .scan_idx     (scan_idx),
        .hit          (hit),
        .clear_en     (clear_en)
    );

    assign eligible = !ent_mask[scan_idx] && pin_pending[scan_idx];

    storm_counter_bank #(.NPINS(NPINS), .STORM_LIMIT(STORM_LIMIT)) u_storm (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (clear_en),
        .idx       (scan_idx),
        .eligible  (eligible),
        .storm_hit (storm_hit),
        .redo_now  (redo_now)
    );

    sweep_timer #(.SWEEP_DELAY(SWEEP_DELAY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (storm_hit),
        .fire  (sweep_fire)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign ack_pulse[g]  = hit      && (scan_idx == IDX_W'(g));
        assign remote_clr[g] = clear_en && (scan_idx == IDX_W'(g));
        assign scan_redo[g]  = redo_now && (scan_idx == IDX_W'(g));
    end

    assign sweep_set = sweep_fire ? (ent_level & pin_pending & ~ent_remote) : '0;
    assign redeliver = scan_redo | sweep_set;

    assert_single_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_pulse));

    assert_clr_within_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_clr & ~ack_pulse) == '0);

    assert_redo_after_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_redo & ~remote_clr) == '0);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ack_pulse == '0 && remote_clr == '0));
endmodule

// File: tb/eoi_throttle_bench.sv
module eoi_throttle_bench;
    localparam int NP  = 24;
    localparam int VW  = 8;
    localparam int LIM = 3;
    localparam int DLY = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eoi_valid = 1'b0, eoi_level = 1'b0, eoi_suppress = 1'b0;
    logic [VW-1:0] eoi_vector = '0;
    logic eoi_ready, busy;
    logic [NP*VW-1:0] ent_vector;
    logic [NP-1:0] tb_lvl = '0, tb_mask = '0, tb_rem = '0, tb_pend = '0;
    logic [NP-1:0] ack_pulse, remote_clr, redeliver;
    logic [VW-1:0] tb_vec [NP];

    int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
    int mcnt [NP];
    int prev_acc = -1;

    typedef struct {
        logic [NP-1:0] ack;
        logic [NP-1:0] clr;
        logic [NP-1:0] redo;
        int            gap;
        string         req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc++;

    always_comb
        for (int i = 0; i < NP; i++) ent_vector[i*VW +: VW] = tb_vec[i];

    eoi_throttle #(.NPINS(NP), .VEC_W(VW), .STORM_LIMIT(LIM), .SWEEP_DELAY(DLY)) u_eoi_throttle (
        .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
        .eoi_vector(eoi_vector), .eoi_level(eoi_level), .eoi_suppress(eoi_suppress),
        .ent_vector(ent_vector), .ent_level(tb_lvl), .ent_mask(tb_mask),
        .ent_remote(tb_rem), .pin_pending(tb_pend), .busy(busy),
        .ack_pulse(ack_pulse), .remote_clr(remote_clr), .redeliver(redeliver)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n && (ack_pulse != '0 || remote_clr != '0 || redeliver != '0)) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R5/R8 unexpected output: actual ack=%h clr=%h redo=%h expected none",
                         ack_pulse, remote_clr, redeliver);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (ack_pulse != e.ack || remote_clr != e.clr || redeliver != e.redo ||
                    (e.gap != 0 && (cyc - last_cyc) != e.gap)) begin
                    errors++;
                    $display("FAIL %s: actual ack=%h clr=%h redo=%h gap=%0d expected ack=%h clr=%h redo=%h gap=%0d",
                             e.req, ack_pulse, remote_clr, redeliver, cyc - last_cyc,
                             e.ack, e.clr, e.redo, e.gap);
                end
            end
            last_cyc = cyc;
        end
    end

    // driver: models requirements R1-style scan, pushes expectations, then hands the notice over
    task automatic send(input logic [VW-1:0] v, input logic lvl, input logic sup,
                        input bit chained, input string req);
        int last_i = -1;
        for (int i = 0; i < NP; i++) begin
            if (tb_vec[i] == v) begin
                exp_t e;
                e.ack = '0; e.clr = '0; e.redo = '0; e.req = req;
                e.ack[i] = 1'b1;
                e.gap = (last_i < 0) ? 0 : (i - last_i);
                if (lvl && !sup) begin
                    e.clr[i] = 1'b1;
                    if (!tb_mask[i] && tb_pend[i]) begin
                        if (mcnt[i] + 1 == LIM) mcnt[i] = 0;
                        else begin mcnt[i]++; e.redo[i] = 1'b1; end
                    end else mcnt[i] = 0;
                end
                q.push_back(e);
                last_i = i;
            end
        end
        @(posedge clk); #1;
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl; eoi_suppress = sup;
        forever begin
            @(negedge clk);
            if (eoi_ready) break;
        end
        @(posedge clk); #1;
        eoi_valid = 1'b0;
        if (chained) chk(cyc - prev_acc == NP + 1, "R9", "accept spacing", cyc - prev_acc, NP + 1);
        prev_acc = cyc;
        @(negedge clk);
        chk(busy && !eoi_ready, "R9", "busy/ready during scan", {busy, eoi_ready}, 2);
    endtask

    task automatic push_sweep(input int gap, input string req);
        exp_t s;
        s.ack = '0; s.clr = '0; s.redo = tb_lvl & tb_pend & ~tb_rem; s.gap = gap; s.req = req;
        q.push_back(s);
    endtask

    task automatic drain(input int max_cyc, input string req);
        for (int k = 0; k < max_cyc && q.size() != 0; k++) @(negedge clk);
        while (busy) @(negedge clk);
        chk(q.size() == 0, req, "items outstanding", q.size(), 0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NP; i++) mcnt[i] = 0;
        prev_acc = -1;
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin tb_vec[i] = VW'(8'h10 + i); mcnt[i] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(eoi_ready == 1'b1, "R9", "ready after reset", eoi_ready, 1);
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
        chk(ack_pulse == '0 && redeliver == '0 && remote_clr == '0, "R2", "outputs after reset", 1, 0);

        // R1 R2 R3 R4: several matches with mixed modes, two notices back to back
        tb_vec[2] = 8'h41;                                   // edge entry
        tb_vec[7] = 8'h41; tb_lvl[7] = 1; tb_mask[7] = 1; tb_pend[7] = 1;
        tb_vec[11] = 8'h41; tb_lvl[11] = 1; tb_pend[11] = 1;
        tb_vec[20] = 8'h41; tb_lvl[20] = 1;                  // not pending
        tb_vec[9] = 8'h30; tb_lvl[9] = 1; tb_pend[9] = 1; tb_rem[9] = 1;
        send(8'h41, 1'b1, 1'b0, 1'b0, "R1 R3 R4 level notice");
        send(8'h41, 1'b1, 1'b0, 1'b1, "R1 R4 second notice");
        drain(100, "R1");

        // R2 R3: suppressed and edge-type notices only acknowledge
        send(8'h41, 1'b1, 1'b1, 1'b0, "R2 R3 suppressed");
        send(8'h41, 1'b0, 1'b0, 1'b1, "R2 R3 edge notice");
        send(8'h77, 1'b1, 1'b0, 1'b0, "R1 no match");
        drain(100, "R2");

        // R5 R6: single pin storm, sweep after exact delay
        tb_vec[5] = 8'h52; tb_lvl[5] = 1; tb_pend[5] = 1;
        for (int n = 0; n < LIM; n++) send(8'h52, 1'b1, 1'b0, 1'b0, "R4 R5 storm pin5");
        push_sweep(DLY, "R6 sweep timing and set");
        drain(3 * DLY, "R6");

        // R7: two pins reach the limit one cycle apart, one sweep only
        tb_vec[5] = 8'h63; tb_vec[6] = 8'h63; tb_lvl[6] = 1; tb_pend[6] = 1;
        for (int n = 0; n < LIM; n++) send(8'h63, 1'b1, 1'b0, 1'b0, "R1 R5 double storm");
        push_sweep(DLY - 1, "R7 no restart");
        drain(3 * DLY, "R7");
        repeat (2 * DLY) @(negedge clk);
        chk(q.size() == 0, "R7", "single sweep", q.size(), 0);

        // R8: reset cancels a running sweep and clears counters
        for (int n = 0; n < LIM + 2; n++) send(8'h63, 1'b1, 1'b0, 1'b0, "R5 R8 pre-reset");
        while (busy) @(negedge clk);
        chk(q.size() == 0, "R8", "pre-reset items", q.size(), 0);
        do_reset();
        repeat (3 * DLY) @(negedge clk);
        chk(eoi_ready == 1'b1, "R8", "ready after mid-run reset", eoi_ready, 1);
        for (int n = 0; n < LIM - 1; n++) send(8'h63, 1'b1, 1'b0, 1'b0, "R8 counters cleared");
        drain(100, "R8");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule